// File: doc/BRIEF.md
# Periodic Reference and Capture Timer Channel

This block is one 16-bit timer channel. A prescaler divides the system clock by a programmable ratio and steps a counter. The counter is compared with a reference value. It can restart at each match to give a fixed period, or keep running and wrap. A strobe input can freeze the present count into a capture register on a chosen edge. Match and capture are recorded as two event flags. Software clears each flag by writing a one to it. The flags raise an interrupt request towards an interrupt controller.

Software drives the channel through a small register port with single-cycle writes and combinational reads. A control register starts and stops the channel. Clearing its run bit returns the channel to its idle state, and a separate hold bit pauses counting. A typical setup selects restart mode and enables the match interrupt. It loads a reference of N, clears stale events with an all-ones write, and then sets the run bit. An interrupt then arrives every N prescaled ticks.

Top module: `tmr_chan`

## Requirements
- R1: Control register at offset 0: bit 4 is run and bit 0 is hold. While run is 0, the counter, prescaler, capture register and both event flags are held at zero on the next clock, and a write to the counter is ignored. After reset every register reads zero and irq is low.
- R2: The prescale field is mode bits 15:8 (PS). While run is 1 and hold is 0, the counter advances once every PS+1 clocks, so PS=0 means every clock.
- R3: A match occurs when an advance would bring the counter to the reference value. At that clock edge the match flag (event bit 1) sets and ref_pulse goes high for exactly one cycle. With restart (mode bit 3) set, the counter goes to zero instead, giving a period of reference × (PS+1) clocks.
- R4: With restart clear, the counter takes the matching value and keeps counting, wrapping from 0xFFFF to 0x0000.
- R5: The match flag is recorded whether or not the match-interrupt enable (mode bit 4) is set. That bit only gates the flag onto irq.
- R6: The edge field is mode bits 7:6, encoded as 00 off, 01 rising, 10 falling and 11 both. It applies to cap_in, which is sampled on the clock. On a selected edge, the capture register (offset 4, read-only) takes the counter value of that cycle and the capture flag (event bit 0) sets. With 00, neither changes.
- R7: Event register at offset 5: bit 1 is the match flag and bit 0 is the capture flag. Writing 1 to a bit clears it, writing 0 leaves it alone, 0xFFFF clears both, and bits 15:2 read as zero.
- R8: If a clearing write and a new event of the same kind fall on the same clock edge, the flag stays set.
- R9: irq = capture flag OR (match flag AND mode bit 4). irq stays high until every flag that drives it has been cleared.
- R10: A write to offset 3 loads the counter, and this takes priority over an advance in the same cycle. Counting continues from the loaded value.
- R11: With run 1 and hold 1, the counter and prescaler keep their values, while counter loads and captures still act.
- R12: Offsets 0 (control), 1 (mode), 2 (reference) and 3 (counter) read back what was last stored. Offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| cap_in | input | 1 | Capture strobe, synchronous to clk |
| irq | output | 1 | Interrupt request |
| ref_pulse | output | 1 | One-cycle pulse per reference match |

## Verification
The assertions take for granted that cap_in is already synchronous to clk, because they treat the edge decision as made in the cycle the level changes. They also assume register writes last one cycle with a stable offset. The stimulus changes cap_in and the write signals only on the falling clock edge, and it never drives two writes closer than one full cycle apart. It also resets the channel through the run bit before it shrinks the reference or prescale value. This keeps the counter from overshooting into a full 16-bit wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
   localparam logic [ADDR_W-1:0] A_REF  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CAP  = 3'd4;
   localparam logic [ADDR_W-1:0] A_EVT  = 3'd5;

   localparam int CTL_HOLD_B   = 0;
   localparam int CTL_RUN_B    = 4;
   localparam int MD_RESTART_B = 3;
   localparam int MD_REFIE_B   = 4;
   localparam int MD_EDGE_LO   = 6;
   localparam int MD_PS_LO     = 8;

   localparam int EV_CAP_B = 0;
   localparam int EV_REF_B = 1;
   localparam int EV_N     = 2;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PSW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           run,
   input  logic [PSW-1:0] div,
   output logic           tick
);
   logic [PSW-1:0] pc_q;

   assign tick = run & ~clr & (pc_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q <= '0;
      else if (clr)   pc_q <= '0;
      else if (run)   pc_q <= (pc_q == div) ? '0 : pc_q + 1'b1;
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic          restart,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic [CW-1:0] ref_val,
   output logic [CW-1:0] cnt,
   output logic          match
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nxt;

   assign nxt   = cnt_q + 1'b1;
   assign match = tick & ~ld & ~clr & (nxt == ref_val);
   assign cnt   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (ld)     cnt_q <= ld_val;
      else if (tick)   cnt_q <= (match & restart) ? '0 : nxt;
   end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
   import tmr_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          strobe,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] cnt,
   output logic [CW-1:0] cap_val,
   output logic          hit
);
   logic s;
   logic prev_q;
   logic rise, fall, sel;
   logic [CW-1:0] cap_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s = strobe;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else begin
               sh_q[0] <= strobe;
               for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = s & ~prev_q;
   assign fall = ~s & prev_q;

   always_comb begin
      case (edge_sel_e'(mode))
         EDGE_RISE: sel = rise;
         EDGE_FALL: sel = fall;
         EDGE_ANY:  sel = rise | fall;
         default:   sel = 1'b0;
      endcase
   end

   assign hit     = sel & ~clr;
   assign cap_val = cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cap_q  <= '0;
      end else begin
         prev_q <= s;
         if (clr)      cap_q <= '0;
         else if (hit) cap_q <= cnt;
      end
   end
endmodule

// File: rtl/tmr_events.sv
module tmr_events #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set,
   input  logic [N-1:0] wclr,
   output logic [N-1:0] ev
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (clr)    f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (wclr[i]) f_q <= 1'b0;
         end
         assign ev[i] = f_q;
      end
   endgenerate
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CW          = 16,
   parameter int PSW         = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CW-1:0]     reg_wdata,
   output logic [CW-1:0]     reg_rdata,
   input  logic              cap_in,
   output logic              irq,
   output logic              ref_pulse
);
   localparam int MODE_TOP = MD_PS_LO + PSW;

   generate
      if (CW < 8) begin : g_bad_cw
         $error("tmr_chan: CW must be at least 8");
      end
      if (MODE_TOP > CW) begin : g_bad_psw
         $error("tmr_chan: prescale field does not fit the mode register");
      end
   endgenerate

   logic          run_q, hold_q;
   logic [CW-1:0] mode_q, ref_q;
   logic          clr, tick, match, hit, pulse_q;
   logic [CW-1:0] cnt, cap_val;
   logic [EV_N-1:0] ev, ev_set, ev_wclr;
   logic          wr_ctl, wr_mode, wr_ref, wr_cnt, wr_evt;

   assign wr_ctl  = reg_wr & (reg_addr == A_CTL);
   assign wr_mode = reg_wr & (reg_addr == A_MODE);
   assign wr_ref  = reg_wr & (reg_addr == A_REF);
   assign wr_cnt  = reg_wr & (reg_addr == A_CNT);
   assign wr_evt  = reg_wr & (reg_addr == A_EVT);

   assign clr = ~run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         hold_q  <= 1'b0;
         mode_q  <= '0;
         ref_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            run_q  <= reg_wdata[CTL_RUN_B];
            hold_q <= reg_wdata[CTL_HOLD_B];
         end
         if (wr_mode) mode_q <= reg_wdata;
         if (wr_ref)  ref_q  <= reg_wdata;
         pulse_q <= match;
      end
   end

   tmr_prescale #(.PSW(PSW)) u_ps (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .run  (~hold_q),
      .div  (mode_q[MD_PS_LO +: PSW]),
      .tick (tick)
   );

   tmr_counter #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .tick   (tick),
      .restart(mode_q[MD_RESTART_B]),
      .ld     (wr_cnt),
      .ld_val (reg_wdata),
      .ref_val(ref_q),
      .cnt    (cnt),
      .match  (match)
   );

   tmr_capture #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .strobe (cap_in),
      .mode   (mode_q[MD_EDGE_LO +: 2]),
      .cnt    (cnt),
      .cap_val(cap_val),
      .hit    (hit)
   );

   always_comb begin
      ev_set           = '0;
      ev_set[EV_REF_B] = match;
      ev_set[EV_CAP_B] = hit;
      ev_wclr          = wr_evt ? reg_wdata[EV_N-1:0] : '0;
   end

   tmr_events #(.N(EV_N)) u_ev (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .set  (ev_set),
      .wclr (ev_wclr),
      .ev   (ev)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTL: begin
            reg_rdata[CTL_RUN_B]  = run_q;
            reg_rdata[CTL_HOLD_B] = hold_q;
         end
         A_MODE:  reg_rdata = mode_q;
         A_REF:   reg_rdata = ref_q;
         A_CNT:   reg_rdata = cnt;
         A_CAP:   reg_rdata = cap_val;
         A_EVT:   reg_rdata[EV_N-1:0] = ev;
         default: reg_rdata = '0;
      endcase
   end

   assign irq       = ev[EV_CAP_B] | (ev[EV_REF_B] & mode_q[MD_REFIE_B]);
   assign ref_pulse = pulse_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [2:0]    reg_addr,
   input logic          irq,
   input logic          ref_pulse,
   input logic          run,
   input logic          hold,
   input logic [CW-1:0] cnt,
   input logic [CW-1:0] cap_val,
   input logic [1:0]    edge_mode,
   input logic          ev_ref,
   input logic          ev_cap
);
   // R1
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0 && cap_val == '0 && !ev_ref && !ev_cap));

   // R3
   pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |-> ev_ref);

   // R6
   capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && edge_mode == 2'b00) |=> $stable(cap_val));

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ev_ref || ev_cap));

   // R9
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_ref && !ev_cap) |-> !irq);

   // R11
   hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hold && !(reg_wr && reg_addr == 3'd3)) |=> $stable(cnt));
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .irq      (irq),
   .ref_pulse(ref_pulse),
   .run      (run_q),
   .hold     (hold_q),
   .cnt      (cnt),
   .cap_val  (cap_val),
   .edge_mode(mode_q[7:6]),
   .ev_ref   (ev[1]),
   .ev_cap   (ev[0])
);

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic        cap_in = 1'b0;
   logic [15:0] reg_rdata;
   logic        irq, ref_pulse;

   int total = 0;
   int bad = 0;
   bit cmp_on = 0;
   bit done = 0;

   // behavioural model state
   int m_run, m_hold, m_mode, m_ref, m_cnt, m_pc, m_cap, m_er, m_ec, m_prev, m_pulse;

   tmr_chan u_tmr_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .cap_in   (cap_in),
      .irq      (irq),
      .ref_pulse(ref_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int ps, em, rs, nc, tick, ld, match, rise, fall, hit, w5, old;
      if (!rst_n) begin
         m_run = 0; m_hold = 0; m_mode = 0; m_ref = 0; m_cnt = 0; m_pc = 0;
         m_cap = 0; m_er = 0; m_ec = 0; m_prev = 0; m_pulse = 0;
      end else begin
         ps    = (m_mode >> 8) & 255;
         em    = (m_mode >> 6) & 3;
         rs    = (m_mode >> 3) & 1;
         tick  = (m_run != 0 && m_hold == 0 && m_pc == ps) ? 1 : 0;
         ld    = (reg_wr && reg_addr == 3) ? 1 : 0;
         w5    = (reg_wr && reg_addr == 5) ? 1 : 0;
         nc    = (m_cnt + 1) & 16'hFFFF;
         match = (m_run != 0 && tick != 0 && ld == 0 && nc == m_ref) ? 1 : 0;
         rise  = (cap_in && m_prev == 0) ? 1 : 0;
         fall  = (!cap_in && m_prev != 0) ? 1 : 0;
         hit   = (m_run != 0 && ((em == 1 && rise != 0) || (em == 2 && fall != 0) ||
                                 (em == 3 && (rise != 0 || fall != 0)))) ? 1 : 0;
         old   = m_cnt;
         if (m_run == 0) begin
            m_cnt = 0; m_pc = 0; m_cap = 0; m_er = 0; m_ec = 0;
         end else begin
            if (m_hold == 0) m_pc = tick ? 0 : ((m_pc + 1) & 255);
            if (ld) m_cnt = reg_wdata;
            else if (tick) m_cnt = (match && rs) ? 0 : nc;
            if (hit) m_cap = old;
            m_er = (match || (m_er && !(w5 && reg_wdata[1]))) ? 1 : 0;
            m_ec = (hit   || (m_ec && !(w5 && reg_wdata[0]))) ? 1 : 0;
         end
         m_pulse = match;
         if (reg_wr && reg_addr == 0) begin
            m_run  = reg_wdata[4];
            m_hold = reg_wdata[0];
         end
         if (reg_wr && reg_addr == 1) m_mode = reg_wdata;
         if (reg_wr && reg_addr == 2) m_ref  = reg_wdata;
         m_prev = cap_in;
      end
   end

   function automatic int exp_rd(int a);
      case (a)
         0: return (m_run << 4) | m_hold;
         1: return m_mode;
         2: return m_ref;
         3: return m_cnt;
         4: return m_cap;
         5: return (m_er << 1) | m_ec;
         default: return 0;
      endcase
   endfunction

   function automatic string rtag(int a);
      case (a)
         0: return "R1 control readback";
         3: return "R2 counter value";
         4: return "R6 capture register";
         5: return "R7 event register";
         default: return "R12 register readback";
      endcase
   endfunction

   // compare against the model on every clock, mid low phase
   always @(negedge clk) begin
      #2;
      if (rst_n && cmp_on && !done) begin
         check(rtag(reg_addr), reg_rdata, exp_rd(reg_addr));
         check("R9 irq vs model", irq, m_ec | (m_er & ((m_mode >> 4) & 1)));
         check("R3 ref_pulse vs model", ref_pulse, m_pulse);
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a[2:0]; reg_wdata = d[15:0];
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      @(negedge clk);
      reg_addr = a[2:0];
      #2 v = reg_rdata;
   endtask

   task automatic set_cap(bit v);
      @(negedge clk);
      cap_in = v;
   endtask

   task automatic pulse_gap(output int gap);
      int c = 0;
      do begin @(negedge clk); #2; c++; end while (!ref_pulse && c < 2000);
      c = 0;
      do begin @(negedge clk); #2; c++; end while (!ref_pulse && c < 2000);
      gap = c;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, g, a0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1;

      // R1 / R12: reset state
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         check("R1 reset value", v, 0);
      end
      check("R1 irq after reset", irq, 0);

      // R3: restart period of 10 with match interrupt
      wr(1, 16'h0018); wr(2, 10); wr(5, 16'hFFFF); wr(0, 16'h0010);
      pulse_gap(g);
      check("R3 restart period", g, 10);
      rd(5, v);
      check("R3 match flag set", v & 2, 2);
      check("R9 irq from match", irq, 1);
      rd(1, v);
      check("R12 mode readback", v, 16'h0018);

      // R2: prescale 3, reference 4 -> 16 clocks
      wr(0, 0); wr(1, 16'h0318); wr(2, 4); wr(0, 16'h0010);
      pulse_gap(g);
      check("R2 prescaled period", g, 16);

      // R5: no match interrupt enable
      wr(0, 0);
      rd(5, v);
      check("R1 run clear empties events", v, 0);
      wr(1, 16'h0008); wr(2, 3); wr(0, 16'h0010);
      pulse_gap(g);
      wr(0, 16'h0011);
      rd(5, v);
      check("R5 match flag recorded", v, 2);
      check("R5 irq stays low", irq, 0);

      // R7: write-one-to-clear
      wr(5, 0);
      rd(5, v);
      check("R7 zero write no effect", v, 2);
      wr(5, 16'h0002);
      rd(5, v);
      check("R7 one write clears", v, 0);

      // R11: hold freezes
      rd(3, a0);
      repeat (10) @(negedge clk);
      rd(3, v);
      check("R11 hold keeps count", v, a0);

      // R6: rising edge capture
      wr(1, 16'h0048);
      set_cap(1);
      rd(5, v);
      check("R6 rising sets capture flag", v, 1);
      rd(4, v);
      check("R6 captured count", v, a0);
      check("R9 irq from capture", irq, 1);
      wr(5, 1);
      check("R9 irq drops when flags clear", irq, 0);
      set_cap(0);
      rd(5, v);
      check("R6 falling ignored in rising mode", v, 0);

      // R6: off mode, R10 load under hold
      wr(1, 16'h0008); wr(3, 16'h0055);
      set_cap(1); set_cap(0);
      rd(4, v);
      check("R6 off keeps capture", v, a0);
      rd(5, v);
      check("R6 off no flag", v, 0);

      // R6: falling mode
      wr(1, 16'h0088);
      set_cap(1);
      rd(5, v);
      check("R6 rise ignored in falling mode", v, 0);
      set_cap(0);
      rd(5, v);
      check("R6 falling sets flag", v, 1);
      rd(4, v);
      check("R6 falling capture value", v, 16'h0055);

      // R6: both edges
      wr(5, 1); wr(1, 16'h00C8); wr(3, 16'h0077);
      set_cap(1);
      rd(4, v);
      check("R6 both-edge capture", v, 16'h0077);

      // R9: irq held until both flags clear
      wr(0, 0); wr(1, 16'h0058); wr(2, 5); wr(0, 16'h0010);
      set_cap(0);
      pulse_gap(g);
      wr(0, 16'h0011);
      set_cap(1);
      rd(5, v);
      check("R9 both flags set", v, 3);
      wr(5, 2);
      check("R9 irq held by capture flag", irq, 1);
      wr(5, 1);
      check("R9 irq low after both clear", irq, 0);

      // R8: set wins over clear
      set_cap(0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h0001; cap_in = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(5, v);
      check("R8 new event beats clear", v, 1);

      // R10, R4: load and wrap without restart
      wr(0, 0); wr(1, 16'h0000); wr(2, 3); wr(0, 16'h0011);
      wr(3, 16'hFFFE);
      rd(3, v);
      check("R10 load under hold", v, 16'hFFFE);
      wr(0, 16'h0010);
      rd(3, v); check("R4 count to FFFF", v, 16'hFFFF);
      rd(3, v); check("R4 wrap to zero", v, 0);
      rd(3, v); check("R4 count 1", v, 1);
      rd(3, v); check("R4 count 2", v, 2);
      rd(3, v); check("R4 reaches reference", v, 3);
      rd(3, v); check("R4 continues past match", v, 4);
      rd(2, v); check("R12 reference readback", v, 3);
      wr(3, 16'h1234);
      rd(3, v);
      check("R10 load wins then counts", v, 16'h1235);
      rd(7, v);
      check("R12 unused offset reads zero", v, 0);
      wr(0, 0);
      rd(3, v);
      check("R1 run clear zeroes counter", v, 0);
      wr(3, 16'h0042);
      rd(3, v);
      check("R1 load ignored while stopped", v, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule